// File: doc/BRIEF.md
# SPI Receive Flag and Overflow Controller

This block sits between the serial shift logic of an SPI peripheral and the CPU. It holds the received data byte and two status flags: receive-full and overflow. A one-cycle strobe from the external shift register reports a completed byte. The CPU sees the flags through status-register reads and takes the byte through data-register reads. Each read is reported to the block as a one-cycle strobe.

Neither flag is cleared by a read on its own. Each flag has an armed bit. A status read that observes the flag set arms it. The next data read clears the flag and consumes the arm. While overflow is set, the receive path is locked: new bytes are dropped, the held byte is kept, and receive-full is not set again. The lock lasts until software reads the status register while overflow is visible and then reads the data register. Two enable bits, written together through a configuration strobe, gate the flags onto a receive interrupt and an error interrupt.

Top module: `spi_rxs_ctrl`

## Requirements
- R1: With receive-full and overflow both clear, a byte-complete strobe sets `rx_full` and loads `byte_in` into `rx_data`, both visible after the next clock edge.
- R2: A byte that completes while `rx_full` is set and no clearing data read happens in the same cycle sets `ovf`. `rx_data` keeps the earlier byte.
- R3: While `ovf` is set, completed bytes are discarded. `rx_full` is not set and `rx_data` does not change.
- R4: A data read clears `rx_full` when an earlier status read saw `rx_full` set and no data read came between them.
- R5: A data read that was not preceded by such a status read leaves `rx_full` set.
- R6: `ovf` clears only on a data read that follows a status read which saw `ovf` set. Other data reads leave it set.
- R7: A data read consumes the arm. A second data read, with no new status read in between, clears nothing.
- R8: When a byte completes in the same cycle as a clearing data read, the byte wins. `rx_full` stays set and `rx_data` takes the new byte.
- R9: `rx_irq` equals `rx_full` AND the receive enable. `err_irq` equals `ovf` AND the error enable. Both enables load from `cfg_rx_ie` and `cfg_err_ie` on `cfg_wr`.
- R10: A synchronous active-high `rst` clears both flags, both arms, both enables and `rx_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_done | input | 1 | Shift register completed a byte |
| byte_in | input | DW | Byte from the shift register |
| stat_rd | input | 1 | CPU status-register read strobe |
| data_rd | input | 1 | CPU data-register read strobe |
| cfg_wr | input | 1 | Load strobe for the interrupt enables |
| cfg_rx_ie | input | 1 | Receive interrupt enable value |
| cfg_err_ie | input | 1 | Error interrupt enable value |
| rx_data | output | DW | Held received byte |
| rx_full | output | 1 | Receive-full flag |
| ovf | output | 1 | Overflow flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The checker watches these rules on every cycle:
- byte acceptance and overrun, and which byte wins on a collision;
- the lock that freezes `rx_data` while overflow is set;
- a data read with no arm never clearing a flag;
- interrupts never asserting without their flag.

The arm-then-read protocol depends on the order of operations across many cycles, so only the bench scenarios show it. These scenarios cover:
- a status read taken before an overflow, so the following data read clears receive-full and leaves overflow set;
- an arm that is consumed and not reused;
- a reset that also drops the enables.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;

    // One status flag together with its arm bit
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    // Interrupt enable pair
    typedef struct packed {
        logic rx_ie;
        logic err_ie;
    } irq_en_t;

    localparam int NFLAG   = 2;
    localparam int IDX_FUL = 0;
    localparam int IDX_OVR = 1;

endpackage

// File: rtl/spi_rxs_flag.sv
module spi_rxs_flag
    import spi_rxs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    output logic flag_o,
    output logic armed_o
);

    flag_st_t st_d, st_q;
    logic     clearing;

    always_comb begin
        st_d     = st_q;
        clearing = data_rd_i && st_q.armed;

        // a new set always wins over a clear in the same cycle
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clearing) begin
            st_d.flag = 1'b0;
        end

        // arm only when the flag is seen and is not being cleared now
        if (stat_rd_i && st_q.flag && !clearing) begin
            st_d.armed = 1'b1;
        end else if (data_rd_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;

endmodule

// File: rtl/spi_rxs_dreg.sv
module spi_rxs_dreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [DW-1:0] byte_i,
    output logic [DW-1:0] data_o
);

    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) begin
            data_d = byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/spi_rxs_ctrl.sv
module spi_rxs_ctrl
    import spi_rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_in,
    input  logic          stat_rd,
    input  logic          data_rd,
    input  logic          cfg_wr,
    input  logic          cfg_rx_ie,
    input  logic          cfg_err_ie,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          ovf,
    output logic          rx_irq,
    output logic          err_irq
);

    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_v;
    logic [NFLAG-1:0] arm_v;
    logic             full_arm;
    logic             ovf_arm;
    logic             full_clearing;
    logic             accept;
    logic             overrun;
    irq_en_t          en_d, en_q;

    assign full_arm = arm_v[IDX_FUL];
    assign ovf_arm  = arm_v[IDX_OVR];

    always_comb begin
        full_clearing = data_rd && full_arm;
        // receive path is locked while overflow is held
        accept  = byte_done && !flag_v[IDX_OVR] &&
                  (!flag_v[IDX_FUL] || full_clearing);
        overrun = byte_done && !flag_v[IDX_OVR] &&
                  flag_v[IDX_FUL] && !full_clearing;
        flag_set[IDX_FUL] = accept;
        flag_set[IDX_OVR] = overrun;

        en_d = en_q;
        if (cfg_wr) begin
            en_d.rx_ie  = cfg_rx_ie;
            en_d.err_ie = cfg_err_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        spi_rxs_flag flag_i (
            .clk       (clk),
            .rst       (rst),
            .set_i     (flag_set[g]),
            .stat_rd_i (stat_rd),
            .data_rd_i (data_rd),
            .flag_o    (flag_v[g]),
            .armed_o   (arm_v[g])
        );
    end

    spi_rxs_dreg #(.DW(DW)) dreg_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .byte_i (byte_in),
        .data_o (rx_data)
    );

    assign rx_full = flag_v[IDX_FUL];
    assign ovf     = flag_v[IDX_OVR];
    assign rx_irq  = rx_full && en_q.rx_ie;
    assign err_irq = ovf && en_q.err_ie;

endmodule

// File: rtl/spi_rxs_chk.sv
module spi_rxs_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          byte_done,
    input logic [DW-1:0] byte_in,
    input logic          data_rd,
    input logic [DW-1:0] rx_data,
    input logic          rx_full,
    input logic          ovf,
    input logic          rx_irq,
    input logic          err_irq,
    input logic          full_arm,
    input logic          ovf_arm
);

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done && !rx_full && !ovf |=> rx_full && rx_data == $past(byte_in));

    // R2
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done && rx_full && !ovf && !(data_rd && full_arm) |=> ovf && $stable(rx_data));

    // R3
    locked_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done && ovf |=> $stable(rx_data));

    // R5
    unarmed_full_chk: assert property (@(posedge clk) disable iff (rst)
        data_rd && !full_arm && rx_full |=> rx_full);

    // R6
    unarmed_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf && !(data_rd && ovf_arm) |=> ovf);

    // R8
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done && data_rd && full_arm && !ovf |=> rx_full && rx_data == $past(byte_in));

    // R9
    rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_full);

    // R9
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> ovf);

endmodule

bind spi_rxs_ctrl spi_rxs_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .byte_done (byte_done),
    .byte_in   (byte_in),
    .data_rd   (data_rd),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .ovf       (ovf),
    .rx_irq    (rx_irq),
    .err_irq   (err_irq),
    .full_arm  (full_arm),
    .ovf_arm   (ovf_arm)
);

// File: tb/spi_rxs_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_rxs_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_done = 1'b0;
    logic [7:0] byte_in = '0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_rx_ie = 1'b0;
    logic       cfg_err_ie = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, ovf, rx_irq, err_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic       full;
        logic       ov;
        logic [7:0] data;
        logic       rirq;
        logic       eirq;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    spi_rxs_ctrl #(.DW(8)) dut_i (
        .clk(clk), .rst(rst), .byte_done(byte_done), .byte_in(byte_in),
        .stat_rd(stat_rd), .data_rd(data_rd), .cfg_wr(cfg_wr),
        .cfg_rx_ie(cfg_rx_ie), .cfg_err_ie(cfg_err_ie),
        .rx_data(rx_data), .rx_full(rx_full), .ovf(ovf),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // driver: one cycle of stimulus plus the state expected after the edge
    task automatic op(input logic r, input logic bd, input logic [7:0] b,
                      input logic sr, input logic dr,
                      input logic cw, input logic rie, input logic eie,
                      input logic ef, input logic eo, input logic [7:0] ed,
                      input logic eri, input logic eei, input string req);
        exp_t e;
        @(negedge clk);
        rst = r; byte_done = bd; byte_in = b; stat_rd = sr; data_rd = dr;
        cfg_wr = cw; cfg_rx_ie = rie; cfg_err_ie = eie;
        e.full = ef; e.ov = eo; e.data = ed; e.rirq = eri; e.eirq = eei; e.req = req;
        sb_q.push_back(e);
        @(posedge clk);
    endtask

    // monitor: compare after each edge once outputs have settled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                tests++;
                if (rx_full !== e.full || ovf !== e.ov || rx_data !== e.data ||
                    rx_irq !== e.rirq || err_irq !== e.eirq) begin
                    fails++;
                    $display("FAIL %s: got full=%b ovf=%b data=%h rirq=%b eirq=%b exp full=%b ovf=%b data=%h rirq=%b eirq=%b",
                             e.req, rx_full, ovf, rx_data, rx_irq, err_irq,
                             e.full, e.ov, e.data, e.rirq, e.eirq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        //  r  bd  byte  sr dr cw ri ei | full ovf data  ri ei
        op(1, 0, 8'h00, 0, 0, 0, 0, 0,   0, 0, 8'h00, 0, 0, "R10 reset");
        op(0, 0, 8'h00, 0, 0, 0, 0, 0,   0, 0, 8'h00, 0, 0, "R10 idle");
        op(0, 1, 8'hA5, 0, 0, 0, 0, 0,   1, 0, 8'hA5, 0, 0, "R1 accept");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   1, 0, 8'hA5, 0, 0, "R5 unarmed read");
        op(0, 0, 8'h00, 1, 0, 0, 0, 0,   1, 0, 8'hA5, 0, 0, "R4 status read");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   0, 0, 8'hA5, 0, 0, "R4 clear full");
        op(0, 1, 8'h3C, 0, 0, 0, 0, 0,   1, 0, 8'h3C, 0, 0, "R1 accept 2");
        op(0, 0, 8'h00, 1, 0, 0, 0, 0,   1, 0, 8'h3C, 0, 0, "R4 status arm");
        op(0, 1, 8'h77, 0, 0, 0, 0, 0,   1, 1, 8'h3C, 0, 0, "R2 overrun");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   0, 1, 8'h3C, 0, 0, "R6 ovf kept");
        op(0, 1, 8'h99, 0, 0, 0, 0, 0,   0, 1, 8'h3C, 0, 0, "R3 locked");
        op(0, 0, 8'h00, 1, 0, 0, 0, 0,   0, 1, 8'h3C, 0, 0, "R6 status ovf");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   0, 0, 8'h3C, 0, 0, "R6 clear ovf");
        op(0, 1, 8'h11, 0, 0, 0, 0, 0,   1, 0, 8'h11, 0, 0, "R1 after unlock");
        op(0, 0, 8'h00, 1, 0, 0, 0, 0,   1, 0, 8'h11, 0, 0, "R7 arm");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   0, 0, 8'h11, 0, 0, "R7 clear");
        op(0, 1, 8'h22, 0, 0, 0, 0, 0,   1, 0, 8'h22, 0, 0, "R7 new byte");
        op(0, 0, 8'h00, 0, 1, 0, 0, 0,   1, 0, 8'h22, 0, 0, "R7 arm consumed");
        op(0, 0, 8'h00, 1, 0, 0, 0, 0,   1, 0, 8'h22, 0, 0, "R8 arm");
        op(0, 1, 8'h44, 0, 1, 0, 0, 0,   1, 0, 8'h44, 0, 0, "R8 collide");
        op(0, 0, 8'h00, 0, 0, 1, 1, 1,   1, 0, 8'h44, 1, 0, "R9 rx irq");
        op(0, 1, 8'h55, 0, 0, 0, 0, 0,   1, 1, 8'h44, 1, 1, "R9 err irq");
        op(0, 0, 8'h00, 0, 0, 1, 0, 1,   1, 1, 8'h44, 0, 1, "R9 rx gate off");
        op(1, 0, 8'h00, 0, 0, 0, 0, 0,   0, 0, 8'h00, 0, 0, "R10 mid reset");
        op(0, 1, 8'h66, 0, 0, 0, 0, 0,   1, 0, 8'h66, 0, 0, "R10 enables cleared");
        op(0, 0, 8'h00, 0, 0, 0, 0, 0,   1, 0, 8'h66, 0, 0, "R10 hold");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule